// File: doc/BRIEF.md
# Programmable Logic Output Macrocell

This block is one output cell of a sum-of-products programmable logic device. It takes a parameterised group of product-term signals from the logic array and ORs them into a single sum. Two configuration bits then decide whether that sum reaches the pin directly or through a D flip-flop, and whether the pin carries the value true or inverted. A separate product term can drive the pin's output enable, and the cell returns a feedback pair to the array.

The flip-flop answers to three controls that all cells share: an asynchronous clear term, a synchronous set term and a test preload path. The preload path can force any chosen state into the register. All three act on the internal stored bit, never on the pin level. After a clear, the pin therefore shows 0 or 1 depending on the chosen polarity. In registered mode the feedback comes from the register, so the pin is output only. In combinational mode the feedback is taken from the pin side of the output buffer, so with the output disabled the pin works as an input.

Top module: `pld_macrocell`

## Requirements
- R1: The sum is the OR of all `NUM_TERMS` product-term inputs. `NUM_TERMS` is one of 8, 10 or 12.
- R2: With `cfg_comb`=0 (registered), each rising clock edge loads the sum into the stored bit Q. Q holds its value between edges.
- R3: With `cfg_true`=1 the pin drive equals the selected source (Q when registered, the sum when combinational). With `cfg_true`=0 the pin drive is that source inverted.
- R4: With `cfg_comb`=1 (combinational), `pin_out` follows the sum in the same cycle, with no clock edge needed.
- R5: While `ar_term` is 1, Q is 0 at once, without waiting for a clock edge. This overrides preload, preset and capture.
- R6: When `sp_term` is 1 at a rising edge, and neither preload nor clear is active, Q becomes 1 whatever the sum is.
- R7: When `pl_en` is 1 at a rising edge and `ar_term` is 0, Q takes `pl_val`. Preload takes priority over preset and over the sum.
- R8: `oe_mode` selects the pin enable: 2'b00 forces it off, 2'b01 forces it on, and 2'b10 or 2'b11 makes it follow `oe_term`.
- R9: In registered mode `fb_true` is the inverse of Q and `fb_comp` equals Q. Neither depends on `pin_in`.
- R10: In combinational mode `fb_true` is the pin-side level: `pin_out` while enabled, `pin_in` while disabled. `fb_comp` is always its inverse.
- R11: A rising edge with `rst_n`=0 clears Q to 0. The pin then reads 0 with true polarity and 1 with inverted polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset of the stored bit |
| pterm | input | NUM_TERMS | Logic product terms to be summed |
| cfg_comb | input | 1 | 1 = combinational, 0 = registered |
| cfg_true | input | 1 | 1 = true output, 0 = inverted output |
| oe_mode | input | 2 | Output enable source: off, on, or term driven |
| oe_term | input | 1 | Dedicated output-enable product term |
| ar_term | input | 1 | Shared asynchronous clear term |
| sp_term | input | 1 | Shared synchronous set term |
| pl_en | input | 1 | Test preload strobe |
| pl_val | input | 1 | Value to preload into the register |
| pin_in | input | 1 | Level seen on the external pin |
| pin_out | output | 1 | Pin drive level |
| pin_oe | output | 1 | Pin drive enable |
| fb_true | output | 1 | Feedback to the array, true form |
| fb_comp | output | 1 | Feedback to the array, complement form |

## Verification
The asynchronous clear can coincide with the synchronous set and the preload at the same clock edge, and preload can coincide with the set. The bench raises the clear in the middle of a cycle while preload, set and a nonzero sum are all asserted. It checks that the pin shows the cleared level before the edge and still shows it after the edge. It then drives preload and set together at one edge, with a preload value opposite to what set would give, and checks at the pins that the preload value arrives.

// File: rtl/pld_mc_pkg.sv
// Package: shared types for the programmable logic output macrocell.
// Assumes nothing beyond plain two-bit encodings.
package pld_mc_pkg;

    // Output enable source selection.
    typedef enum logic [1:0] {
        OE_OFF  = 2'b00,
        OE_ON   = 2'b01,
        OE_TERM = 2'b10,
        OE_TRM2 = 2'b11
    } oe_sel_e;

    // Feedback pair returned to the logic array.
    typedef struct packed {
        logic t;
        logic c;
    } fb_pair_t;

endpackage

// File: rtl/pld_mc_sum.sv
// Module: pld_mc_sum
// ORs the logic product terms of one cell into a single sum term.
// Assumes NUM_TERMS is one of 8, 10 or 12 (the position of the cell picks it).
module pld_mc_sum #(
    parameter int NUM_TERMS = 8
) (
    input  logic [NUM_TERMS-1:0] terms,
    output logic                 sum
);

    localparam int LAST = NUM_TERMS - 1;

    logic [NUM_TERMS-1:0] chain;

    // Running OR along the term vector, one stage per term.
    genvar gi;
    generate
        for (gi = 0; gi < NUM_TERMS; gi++) begin : g_or
            if (gi == 0) begin : g_first
                assign chain[gi] = terms[gi];
            end else begin : g_next
                assign chain[gi] = chain[gi-1] | terms[gi];
            end
        end
    endgenerate

    // The last stage of the chain is the sum term.
    assign sum = chain[LAST];

endmodule

// File: rtl/pld_mc_state.sv
// Module: pld_mc_state
// The macrocell's D flip-flop. Priority, highest first:
// asynchronous clear, synchronous reset, preload, synchronous set, D capture.
// Assumes ar_term is glitch-free, since it is used as an asynchronous clear.
module pld_mc_state (
    input  logic clk,
    input  logic rst_n,
    input  logic ar_term,
    input  logic sp_term,
    input  logic pl_en,
    input  logic pl_val,
    input  logic d_in,
    output logic q
);

    logic d_next;

    // Next-state selection among preload, set and capture.
    always_comb begin
        if (pl_en) begin
            d_next = pl_val;
        end else if (sp_term) begin
            d_next = 1'b1;
        end else begin
            d_next = d_in;
        end
    end

    // Stored bit with asynchronous clear and synchronous active-low reset.
    always_ff @(posedge clk or posedge ar_term) begin
        if (ar_term) begin
            q <= 1'b0;
        end else if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= d_next;
        end
    end

endmodule

// File: rtl/pld_mc_outpath.sv
// Module: pld_mc_outpath
// Picks the pin source (register or sum), applies polarity, decodes the
// output enable and forms the feedback pair for the array.
// Assumes pin_in reflects the pad level, including this cell's own drive.
module pld_mc_outpath
    import pld_mc_pkg::*;
(
    input  logic     cfg_comb,
    input  logic     cfg_true,
    input  oe_sel_e  oe_sel,
    input  logic     oe_term,
    input  logic     q,
    input  logic     sum,
    input  logic     pin_in,
    output logic     pin_out,
    output logic     pin_oe,
    output fb_pair_t fb
);

    logic src;
    logic pin_side;

    // Pin source: the sum when combinational, the register when registered.
    always_comb src = cfg_comb ? sum : q;

    // Polarity stage: true or inverted drive.
    always_comb pin_out = cfg_true ? src : ~src;

    // Output enable decode.
    always_comb begin
        unique case (oe_sel)
            OE_OFF:  pin_oe = 1'b0;
            OE_ON:   pin_oe = 1'b1;
            default: pin_oe = oe_term;
        endcase
    end

    // Level on the pin side of the enable buffer.
    always_comb pin_side = pin_oe ? pin_out : pin_in;

    // Feedback: inverted register output when registered, pin side otherwise.
    always_comb begin
        if (cfg_comb) begin
            fb.t = pin_side;
            fb.c = ~pin_side;
        end else begin
            fb.t = ~q;
            fb.c = q;
        end
    end

endmodule

// File: rtl/pld_macrocell.sv
// Module: pld_macrocell (top)
// One configurable output cell: sum term, state register, output path.
// Assumes the configuration inputs stay static during normal operation.
module pld_macrocell
    import pld_mc_pkg::*;
#(
    parameter int NUM_TERMS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TERMS-1:0] pterm,
    input  logic                 cfg_comb,
    input  logic                 cfg_true,
    input  logic [1:0]           oe_mode,
    input  logic                 oe_term,
    input  logic                 ar_term,
    input  logic                 sp_term,
    input  logic                 pl_en,
    input  logic                 pl_val,
    input  logic                 pin_in,
    output logic                 pin_out,
    output logic                 pin_oe,
    output logic                 fb_true,
    output logic                 fb_comp
);

    logic     sum_term;
    logic     q_state;
    oe_sel_e  oe_sel;
    fb_pair_t fb_pair;

    // Convert the raw enable mode into its enumerated form.
    always_comb oe_sel = oe_sel_e'(oe_mode);

    pld_mc_sum #(.NUM_TERMS(NUM_TERMS)) u_sum (
        .terms (pterm),
        .sum   (sum_term)
    );

    pld_mc_state u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .ar_term (ar_term),
        .sp_term (sp_term),
        .pl_en   (pl_en),
        .pl_val  (pl_val),
        .d_in    (sum_term),
        .q       (q_state)
    );

    pld_mc_outpath u_out (
        .cfg_comb (cfg_comb),
        .cfg_true (cfg_true),
        .oe_sel   (oe_sel),
        .oe_term  (oe_term),
        .q        (q_state),
        .sum      (sum_term),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .fb       (fb_pair)
    );

    // Feedback pair out to the ports.
    assign fb_true = fb_pair.t;
    assign fb_comp = fb_pair.c;

endmodule

// File: rtl/pld_macrocell_chk.sv
// Module: pld_macrocell_chk
// Property checker for pld_macrocell, attached with the bind below.
// Assumes it sees the stored bit of the state register as q_state.
module pld_macrocell_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_comb,
    input logic       cfg_true,
    input logic [1:0] oe_mode,
    input logic       ar_term,
    input logic       sp_term,
    input logic       pl_en,
    input logic       pl_val,
    input logic       pin_in,
    input logic       pin_out,
    input logic       pin_oe,
    input logic       fb_true,
    input logic       fb_comp,
    input logic       q_state
);

    a_r5_clear_now: assert property (@(posedge clk) disable iff (!rst_n)
        ar_term |-> (q_state == 1'b0));

    a_r6_preset: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_term && !pl_en && !ar_term) |=> (ar_term || q_state));

    a_r7_preload: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_en && !ar_term) |=> (ar_term || (q_state == $past(pl_val))));

    a_r8_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_mode == 2'b00) |-> !pin_oe);

    a_r8_oe_on: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_mode == 2'b01) |-> pin_oe);

    a_r3_reg_true: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_comb && cfg_true) |-> (pin_out == q_state));

    a_r9_reg_fb: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_comb |-> (fb_comp == q_state));

    a_r10_pin_side: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_comb && !pin_oe) |-> (fb_true == pin_in));

    a_r10_pair: assert property (@(posedge clk) disable iff (!rst_n)
        fb_true != fb_comp);

endmodule

bind pld_macrocell pld_macrocell_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_comb (cfg_comb),
    .cfg_true (cfg_true),
    .oe_mode  (oe_mode),
    .ar_term  (ar_term),
    .sp_term  (sp_term),
    .pl_en    (pl_en),
    .pl_val   (pl_val),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .fb_true  (fb_true),
    .fb_comp  (fb_comp),
    .q_state  (q_state)
);

// File: tb/pld_macrocell_test.sv
// Scoreboard bench: the driver pushes predicted pin states into a queue,
// and the monitor pops each one and compares it with the outputs.
module pld_macrocell_test;

    localparam int NT = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NT-1:0] pterm;
    logic          cfg_comb, cfg_true, oe_term, ar_term, sp_term;
    logic          pl_en, pl_val, pin_in;
    logic [1:0]    oe_mode;
    logic          pin_out, pin_oe, fb_true, fb_comp;

    typedef struct {
        logic [3:0] v;
        string      tag;
    } item_t;

    item_t sb[$];
    event  ev_push;
    int    n_chk = 0;
    int    n_bad = 0;
    logic  qm = 1'b0;
    bit    done = 1'b0;

    always #10 clk = ~clk;

    pld_macrocell #(.NUM_TERMS(NT)) uut (
        .clk(clk), .rst_n(rst_n), .pterm(pterm), .cfg_comb(cfg_comb),
        .cfg_true(cfg_true), .oe_mode(oe_mode), .oe_term(oe_term),
        .ar_term(ar_term), .sp_term(sp_term), .pl_en(pl_en), .pl_val(pl_val),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .fb_true(fb_true), .fb_comp(fb_comp)
    );

    // Prediction from the requirements: {pin_out, pin_oe, fb_true, fb_comp}.
    function automatic logic [3:0] predict();
        logic s, oe, po, ft, fc;
        s  = |pterm;
        oe = (oe_mode == 2'b00) ? 1'b0 : (oe_mode == 2'b01) ? 1'b1 : oe_term;
        if (!cfg_comb) begin
            po = cfg_true ? qm : ~qm;
            ft = ~qm;
            fc = qm;
        end else begin
            po = cfg_true ? s : ~s;
            ft = oe ? po : pin_in;
            fc = ~ft;
        end
        return {po, oe, ft, fc};
    endfunction

    // Driver side: push the predicted item and let the monitor take it.
    task automatic expect_now(string tag);
        item_t it;
        it.v   = predict();
        it.tag = tag;
        sb.push_back(it);
        ->ev_push;
        #3;
    endtask

    // Advance one clock, updating the reference bit at the edge.
    task automatic tick();
        @(posedge clk);
        if (ar_term || !rst_n) qm = 1'b0;
        else if (pl_en)        qm = pl_val;
        else if (sp_term)      qm = 1'b1;
        else                   qm = |pterm;
        @(negedge clk);
    endtask

    // Monitor: pop each expected item and compare it with the outputs.
    initial begin
        forever begin
            @(ev_push);
            #1;
            while (sb.size() != 0) begin
                item_t it;
                it = sb.pop_front();
                n_chk++;
                if ({pin_out, pin_oe, fb_true, fb_comp} !== it.v) begin
                    n_bad++;
                    $display("FAIL %s: actual=%b expected=%b", it.tag,
                             {pin_out, pin_oe, fb_true, fb_comp}, it.v);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 50000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pterm = '0; cfg_comb = 1'b0; cfg_true = 1'b1;
        oe_mode = 2'b01; oe_term = 1'b0; ar_term = 1'b0; sp_term = 1'b0;
        pl_en = 1'b0; pl_val = 1'b0; pin_in = 1'b0;
        @(negedge clk);
        pterm = '1;
        tick(); tick();
        expect_now("R11 reset, true polarity");
        cfg_true = 1'b0;
        expect_now("R11 reset, inverted polarity");
        rst_n = 1'b1;

        // R1 and R4: combinational sum of every single term, no clock
        cfg_comb = 1'b1; cfg_true = 1'b1; pterm = '0;
        expect_now("R1 all terms low");
        for (int i = 0; i < NT; i++) begin
            pterm = NT'(1) << i;
            expect_now("R1 single term high");
        end
        pterm = '1;
        expect_now("R1 all terms high");
        cfg_true = 1'b0; pterm = '0;
        expect_now("R4 R3 comb inverted, low sum");
        pterm = 12'h800;
        expect_now("R4 comb follows without clock");

        // R2 registered capture and hold
        cfg_comb = 1'b0; cfg_true = 1'b1; pterm = 12'h004;
        tick();
        expect_now("R2 capture one");
        pterm = '0;
        expect_now("R2 hold between edges");
        tick();
        expect_now("R2 capture zero");
        cfg_true = 1'b0;
        expect_now("R3 registered inverted");

        // R9 registered feedback ignores pin_in
        oe_mode = 2'b00; pin_in = 1'b1;
        expect_now("R9 feedback with pin_in high");
        pin_in = 1'b0;
        expect_now("R9 feedback with pin_in low");

        // R8 enable modes
        oe_mode = 2'b10; oe_term = 1'b1;
        expect_now("R8 term driven on");
        oe_term = 1'b0;
        expect_now("R8 term driven off");
        oe_mode = 2'b11; oe_term = 1'b1;
        expect_now("R8 code 11 term driven");

        // R10 combinational feedback from the pin side
        cfg_comb = 1'b1; cfg_true = 1'b1; oe_mode = 2'b00; pterm = '0; pin_in = 1'b1;
        expect_now("R10 disabled pin reads external high");
        pin_in = 1'b0; pterm = '1;
        expect_now("R10 disabled pin reads external low");
        oe_mode = 2'b01;
        expect_now("R10 enabled pin feeds own drive");

        // R6 synchronous set
        cfg_comb = 1'b0; pterm = '0; sp_term = 1'b1;
        tick();
        expect_now("R6 set overrides zero sum");
        sp_term = 1'b0;
        tick();
        expect_now("R6 set released");

        // R7 preload over set and sum
        pl_en = 1'b1; pl_val = 1'b0; sp_term = 1'b1; pterm = '1;
        tick();
        expect_now("R7 preload zero beats set");
        pl_val = 1'b1; sp_term = 1'b0; pterm = '0;
        tick();
        expect_now("R7 preload one beats sum");

        // R5 asynchronous clear over everything, mid cycle
        pl_en = 1'b0;
        sp_term = 1'b1; pl_en = 1'b1; pl_val = 1'b1; pterm = '1;
        #2;
        ar_term = 1'b1; qm = 1'b0;
        expect_now("R5 clear before edge");
        tick();
        expect_now("R5 clear holds over edge");
        cfg_true = 1'b0;
        expect_now("R5 cleared pin inverted reads one");
        ar_term = 1'b0; sp_term = 1'b0; pl_en = 1'b0;
        cfg_true = 1'b1; pterm = '0;
        tick();
        expect_now("R5 released, sum captured");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule